// File: doc/BRIEF.md
# Frequency-Change Recovery Watchdog

This block protects a clock generator while a host retunes its output frequency. Software first sets a time unit and an interval count with the watchdog disabled, then enables it and attempts the frequency change. If software confirms the change by disabling the watchdog before the interval runs out, nothing happens. If it does not, the block drives a long, active-low system reset pulse.

The block also chooses the frequency code that the synthesizer should use. After reset it passes through the code the host programmed. The first timeout moves the selection to a fixed fallback code. A timeout at the fallback frequency moves it to the code read from the board jumpers. Only a power-on reset returns the selection to the programmed code.

All timing is counted in ticks of a slow enable input, nominally 1 kHz. With default parameters, a unit is 250 or 1000 ticks, the interval is 1 to 256 units, and the pulse lasts 500 ticks.

Top module: `recovery_wdt`

## Requirements
- R1: After rst_ni is asserted, wdt_rst_no is 1, src_o is 2'b00 (programmed source) and freq_code_o equals prog_code_i.
- R2: A cfg_we_i pulse loads unit_sel_i and ivl_i only while wdt_en_i is 0. A write while wdt_en_i is 1 is ignored and the old timeout stays in force.
- R3: With wdt_en_i held at 1, wdt_rst_no falls on the edge of tick number (ivl_i+1)*U counted from enable. U is UNIT_SHORT_TICKS when unit_sel_i is 0 and UNIT_LONG_TICKS when it is 1. While wdt_en_i is 0, ticks do not lead to a timeout.
- R4: Dropping wdt_en_i clears the elapsed count, and re-enabling starts the count again from zero.
- R5: After a timeout, wdt_rst_no stays 0 for exactly PULSE_TICKS ticks and then returns to 1. No new timeout is counted while it is 0, and counting restarts from zero afterwards.
- R6: A timeout while src_o is 2'b00 sets src_o to 2'b01 (fallback), and freq_code_o then equals FALLBACK_CODE.
- R7: A timeout while src_o is 2'b01 sets src_o to 2'b10 (jumper), and freq_code_o then follows jumper_code_i. Later timeouts keep 2'b10 and still produce a reset pulse.
- R8: Disabling the watchdog in time leaves src_o unchanged. Only rst_ni returns src_o to 2'b00.
- R9: Only cycles with tick_i at 1 advance time. Idle cycles between ticks have no effect on when the reset falls or rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| wdt_en_i | input | 1 | Watchdog enable level |
| cfg_we_i | input | 1 | Load strobe for unit and interval |
| unit_sel_i | input | 1 | Unit: 0 = short unit, 1 = long unit |
| ivl_i | input | IVL_W | Interval count minus one |
| prog_code_i | input | CODE_W | Host-programmed frequency code |
| jumper_code_i | input | CODE_W | Frequency code from board jumpers |
| wdt_rst_no | output | 1 | Active-low reset pulse |
| src_o | output | 2 | Source: 00 programmed, 01 fallback, 10 jumper |
| freq_code_o | output | CODE_W | Selected frequency code |

## Verification
The reset output and the source select are registered on the clock edge that consumes the deciding tick, so both change one edge after that tick is presented. freq_code_o is a combinational mux and follows its code inputs in the same cycle. The bench drives tick_i and control on falling edges and samples on the following falling edge, so each result is read in the first cycle it is due. The bench counts ticks against the requirement formulas, checks the output one tick before each boundary and again at the boundary, and inserts random idle gaps between ticks.

// File: rtl/recovery_wdt_pkg.sv
package recovery_wdt_pkg;
  typedef enum logic [1:0] {
    SRC_PROG     = 2'b00,
    SRC_FALLBACK = 2'b01,
    SRC_JUMPER   = 2'b10
  } src_e;
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg #(
  parameter int IVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             unit_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             unit_o,
  output logic [IVL_W-1:0] ivl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_o <= 1'b0;
      ivl_o  <= '0;
    end else if (we_i && !en_i) begin
      unit_o <= unit_i;
      ivl_o  <= ivl_i;
    end
  end

  // R2: config frozen while enabled
  p_cfg_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ($stable(ivl_o) && $stable(unit_o)));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int IVL_W            = 8,
  parameter int UNIT_SHORT_TICKS = 250,
  parameter int UNIT_LONG_TICKS  = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             busy_i,
  input  logic             unit_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             expire_o
);
  localparam int MAX_UNIT = (UNIT_LONG_TICKS > UNIT_SHORT_TICKS) ? UNIT_LONG_TICKS : UNIT_SHORT_TICKS;
  localparam int UCW = $clog2(MAX_UNIT + 1);
  localparam logic [UCW-1:0] SHORT_LAST = UCW'(UNIT_SHORT_TICKS - 1);
  localparam logic [UCW-1:0] LONG_LAST  = UCW'(UNIT_LONG_TICKS - 1);

  logic [UCW-1:0]   unit_cnt_q;
  logic [IVL_W-1:0] ivl_cnt_q;
  logic             unit_last, ivl_last, run;

  assign run       = en_i && !busy_i;
  assign unit_last = unit_cnt_q == (unit_i ? LONG_LAST : SHORT_LAST);
  assign ivl_last  = ivl_cnt_q == ivl_i;
  assign expire_o  = run && tick_i && unit_last && ivl_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_cnt_q <= '0;
      ivl_cnt_q  <= '0;
    end else if (!run) begin
      unit_cnt_q <= '0;
      ivl_cnt_q  <= '0;
    end else if (tick_i) begin
      if (unit_last) begin
        unit_cnt_q <= '0;
        ivl_cnt_q  <= ivl_last ? '0 : ivl_cnt_q + 1'b1;
      end else begin
        unit_cnt_q <= unit_cnt_q + 1'b1;
      end
    end
  end

  // R4: a disable always leaves the count at zero
  p_clear_on_disable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (unit_cnt_q == '0 && ivl_cnt_q == '0));
  // R9: expiry only on a tick while enabled
  p_expire_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (tick_i && en_i && !busy_i));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_TICKS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic busy_o,
  output logic rst_no
);
  localparam int PCW = $clog2(PULSE_TICKS + 1);
  localparam logic [PCW-1:0] P_LAST = PCW'(PULSE_TICKS - 1);

  logic           active_q;
  logic [PCW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (cnt_q == P_LAST) active_q <= 1'b0;
      else                 cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign busy_o = active_q;
  assign rst_no = !active_q;

  // R5: pulse starts only from idle, and only a start makes it fall
  p_start_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> rst_no);
  p_fall_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_no && !start_i) |=> rst_no);
  p_hold_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_no && !tick_i) |=> !rst_no);
endmodule

// File: rtl/wdt_src.sv
module wdt_src
  import recovery_wdt_pkg::*;
#(
  parameter int                CODE_W        = 5,
  parameter logic [CODE_W-1:0] FALLBACK_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  logic [CODE_W-1:0] prog_code_i,
  input  logic [CODE_W-1:0] jumper_code_i,
  output src_e              src_o,
  output logic [CODE_W-1:0] code_o
);
  src_e src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_PROG;
    else if (expire_i) begin
      case (src_q)
        SRC_PROG:     src_q <= SRC_FALLBACK;
        default:      src_q <= SRC_JUMPER;
      endcase
    end
  end

  always_comb begin
    case (src_q)
      SRC_FALLBACK: code_o = FALLBACK_CODE;
      SRC_JUMPER:   code_o = jumper_code_i;
      default:      code_o = prog_code_i;
    endcase
  end

  assign src_o = src_q;

  p_step_fallback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && src_q == SRC_PROG) |=> src_q == SRC_FALLBACK);
  p_step_jumper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && src_q != SRC_PROG) |=> src_q == SRC_JUMPER);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_i |=> $stable(src_q));
endmodule

// File: rtl/recovery_wdt.sv
module recovery_wdt
  import recovery_wdt_pkg::*;
#(
  parameter int                CODE_W           = 5,
  parameter int                IVL_W            = 8,
  parameter int                UNIT_SHORT_TICKS = 250,
  parameter int                UNIT_LONG_TICKS  = 1000,
  parameter int                PULSE_TICKS      = 500,
  parameter logic [CODE_W-1:0] FALLBACK_CODE    = 5'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wdt_en_i,
  input  logic              cfg_we_i,
  input  logic              unit_sel_i,
  input  logic [IVL_W-1:0]  ivl_i,
  input  logic [CODE_W-1:0] prog_code_i,
  input  logic [CODE_W-1:0] jumper_code_i,
  output logic              wdt_rst_no,
  output logic [1:0]        src_o,
  output logic [CODE_W-1:0] freq_code_o
);
  logic             unit_q;
  logic [IVL_W-1:0] ivl_q;
  logic             expire, busy;
  src_e             src;

  wdt_cfg #(.IVL_W(IVL_W)) u_cfg (
    .clk_i, .rst_ni, .en_i(wdt_en_i), .we_i(cfg_we_i),
    .unit_i(unit_sel_i), .ivl_i, .unit_o(unit_q), .ivl_o(ivl_q)
  );

  wdt_timer #(
    .IVL_W(IVL_W), .UNIT_SHORT_TICKS(UNIT_SHORT_TICKS), .UNIT_LONG_TICKS(UNIT_LONG_TICKS)
  ) u_timer (
    .clk_i, .rst_ni, .tick_i, .en_i(wdt_en_i), .busy_i(busy),
    .unit_i(unit_q), .ivl_i(ivl_q), .expire_o(expire)
  );

  wdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk_i, .rst_ni, .tick_i, .start_i(expire), .busy_o(busy), .rst_no(wdt_rst_no)
  );

  wdt_src #(.CODE_W(CODE_W), .FALLBACK_CODE(FALLBACK_CODE)) u_src (
    .clk_i, .rst_ni, .expire_i(expire), .prog_code_i, .jumper_code_i,
    .src_o(src), .code_o(freq_code_o)
  );

  assign src_o = src;

  // R1/R7: select never takes the unused code
  p_src_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_o != 2'b11);
endmodule

// File: tb/recovery_wdt_bench.sv
module recovery_wdt_bench;
  localparam int CW = 5, IW = 8, US = 3, UL = 5, PT = 4;
  localparam logic [CW-1:0] FB = 5'h1A;

  logic clk = 0, rst_ni = 0, tick_i = 0, en = 0, we = 0, unit = 0;
  logic [IW-1:0] ivl = 0;
  logic [CW-1:0] prog = 5'h05, jmp = 5'h11;
  logic wdt_rst_no;
  logic [1:0] src;
  logic [CW-1:0] code;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  recovery_wdt #(.CODE_W(CW), .IVL_W(IW), .UNIT_SHORT_TICKS(US), .UNIT_LONG_TICKS(UL),
                 .PULSE_TICKS(PT), .FALLBACK_CODE(FB)) u_recovery_wdt (
    .clk_i(clk), .rst_ni, .tick_i, .wdt_en_i(en), .cfg_we_i(we), .unit_sel_i(unit),
    .ivl_i(ivl), .prog_code_i(prog), .jumper_code_i(jmp), .wdt_rst_no,
    .src_o(src), .freq_code_o(code)
  );

  function automatic int timeout_ticks(input logic u, input logic [IW-1:0] v);
    return (int'(v) + 1) * (u ? UL : US);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1; @(negedge clk); tick_i = 0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic cfg(input logic u, input logic [IW-1:0] v);
    unit = u; ivl = v; we = 1; @(negedge clk); we = 0;
  endtask

  task automatic expect_timeout(input int n, input string req);
    ticks(n - 1);
    check({req, " high before boundary"}, wdt_rst_no, 1);
    ticks(1);
    check({req, " low at boundary"}, wdt_rst_no, 0);
  endtask

  task automatic expect_pulse();
    ticks(PT - 1);
    check("R5 low until last pulse tick", wdt_rst_no, 0);
    ticks(1);
    check("R5 high after pulse", wdt_rst_no, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1; @(negedge clk);
    check("R1 reset high", wdt_rst_no, 1);
    check("R1 source prog", src, 0);
    check("R1 code prog", code, prog);
    prog = 5'h0C; #1;
    check("R1 code follows prog", code, 5'h0C);

    // ticks while disabled do nothing (R3)
    cfg(0, 8'd1);
    ticks(20);
    check("R3 disabled no timeout", wdt_rst_no, 1);

    // first timeout -> fallback (R3, R6, R9)
    en = 1; @(negedge clk);
    expect_timeout(timeout_ticks(0, 8'd1), "R3 R9");
    check("R6 source fallback", src, 1);
    check("R6 code fallback", code, FB);
    expect_pulse();

    // write while enabled ignored (R2): new cfg would fire at 5 ticks
    cfg(1, 8'd0);
    ticks(5);
    check("R2 write ignored", wdt_rst_no, 1);
    en = 0; @(negedge clk);
    check("R8 disable keeps fallback", src, 1);

    // disable clears count (R4)
    en = 1; @(negedge clk);
    ticks(4);
    en = 0; @(negedge clk);
    en = 1; @(negedge clk);
    expect_timeout(timeout_ticks(0, 8'd1), "R4");
    check("R7 source jumper", src, 2);
    check("R7 code jumper", code, jmp);
    jmp = 5'h07; #1;
    check("R7 code follows jumper", code, 5'h07);
    expect_pulse();
    en = 0; @(negedge clk);

    // long unit, loaded while disabled (R2, R3)
    cfg(1, 8'd0);
    en = 1; @(negedge clk);
    expect_timeout(timeout_ticks(1, 8'd0), "R2 R3 long");
    check("R7 stays jumper", src, 2);
    expect_pulse();
    en = 0; @(negedge clk);

    // random configs
    for (int k = 0; k < 20; k++) begin
      logic u;
      logic [IW-1:0] v;
      u = 1'($urandom_range(0, 1));
      v = IW'($urandom_range(0, 7));
      jmp = CW'($urandom);
      cfg(u, v);
      en = 1; @(negedge clk);
      if (k % 3 == 0) begin
        ticks(timeout_ticks(u, v) - 1);
        en = 0; @(negedge clk);
        check("R8 in-time disable no pulse", wdt_rst_no, 1);
      end else begin
        expect_timeout(timeout_ticks(u, v), "R3 R9 random");
        check("R7 random code jumper", code, jmp);
        expect_pulse();
        en = 0; @(negedge clk);
      end
      check("R7 random source jumper", src, 2);
    end

    // only power-on reset returns to prog (R8)
    rst_ni = 0; @(negedge clk);
    rst_ni = 1; @(negedge clk);
    check("R8 reset to prog", src, 0);
    check("R1 code after reset", code, prog);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule